// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a small bank of hardware semaphores shared by two requesting ports, A and B. Each semaphore holds two bits: a reserved flag and a holder bit that names the port that took it last. A port claims a semaphore with a single read. The claim happens inside that access, so there is no read-modify-write sequence and no window in which the other port can slip in. The response to the read tells the port whether it now holds the semaphore. Software on the two sides decides which shared resource each semaphore guards. The block knows nothing of that mapping.

Only the current holder can change a semaphore, by writing to it. An all-zero write releases the semaphore. A write from the other port does nothing. The two ports behave the same way with their roles swapped. When both ports reach the same semaphore in one cycle, fixed rules decide which access is applied first. Each access gets a registered response one cycle after it was presented.

Top module: `sem_bank`

## Requirements
- R1: There are NSEM (default 8) semaphores. An access to one index never changes another, and two accesses to different indices in the same cycle are each handled as if alone.
- R2: A synchronous active-high reset makes every semaphore free with holder bit 0 (port A). While reset is high, both rvalid outputs and both rdata outputs are zero.
- R3: A read of a free semaphore succeeds. The semaphore becomes reserved and its holder bit becomes the reading port (0 = A, 1 = B).
- R4: A read of a semaphore reserved by the other port fails and changes nothing.
- R5: A read by the port that already holds the semaphore succeeds and changes nothing.
- R6: A write by the holder of a reserved semaphore succeeds. If the write data is all zeros, the semaphore becomes free and the holder bit keeps its value. Any nonzero data leaves the semaphore reserved.
- R7: A write by a port that does not hold the semaphore fails and changes nothing. This includes any write to a free semaphore.
- R8: When one port reads and the other writes the same index in the same cycle, the write is applied first and the read sees its result.
- R9: When both ports read, or both ports write, the same index in the same cycle, port A is applied first and port B sees the result.
- R10: Both ports obey identical rules with their roles mirrored.
- R11: Each access gets a response one cycle after the request, on rvalid = 1. The response fields are: rdata bit 0 = success, bit 1 = holder bit, bit 2 = reserved flag, all other bits 0. The holder and reserved fields are taken after this port's own access is applied. A cycle with no request gives rvalid = 0 and rdata = 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_req | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_idx | input | IW | Port A semaphore index |
| a_wdata | input | DW | Port A write data, all zeros releases |
| b_req | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_idx | input | IW | Port B semaphore index |
| b_wdata | input | DW | Port B write data, all zeros releases |
| a_rvalid | output | 1 | Port A response valid |
| a_rdata | output | DW | Port A response: success, holder, reserved |
| b_rvalid | output | 1 | Port B response valid |
| b_rdata | output | DW | Port B response: success, holder, reserved |

## Verification
Every response is due exactly one clock edge after its request. Semaphore state changes become visible to the next access presented after that same edge. The bench applies inputs on the falling edge. On the following falling edge it compares both response ports with a behavioural model that computed the result when the stimulus was applied. The check therefore lands exactly one register stage later. Directed sequences cover claiming, refusals, releases and each same-index collision order. A long mirrored random phase then exercises both ports against the model on every cycle.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef struct packed {
    logic busy;
    logic owner;
  } sem_t;

  localparam logic PORT_A = 1'b0;
  localparam logic PORT_B = 1'b1;

  localparam int RSP_OK  = 0;
  localparam int RSP_OWN = 1;
  localparam int RSP_RES = 2;
  localparam int RSP_W   = 3;
endpackage

// File: rtl/sem_route.sv
module sem_route #(
  parameter int NSEM = 8,
  parameter int IW   = $clog2(NSEM)
) (
  input  logic            a_req,
  input  logic            a_we,
  input  logic [IW-1:0]   a_idx,
  input  logic            b_req,
  input  logic            b_we,
  input  logic [IW-1:0]   b_idx,
  output logic [NSEM-1:0] a_hit,
  output logic [NSEM-1:0] b_hit,
  output logic            b_first
);
  // A write on port B against a read on port A is the only case where B goes first.
  assign b_first = b_we & ~a_we;

  for (genvar i = 0; i < NSEM; i++) begin : g_dec
    assign a_hit[i] = a_req && (a_idx == IW'(i));
    assign b_hit[i] = b_req && (b_idx == IW'(i));
  end
endmodule

// File: rtl/sem_step.sv
module sem_step
  import sem_pkg::*;
(
  input  sem_t cur,
  input  logic hit,
  input  logic we,
  input  logic rel,
  input  logic port,
  output sem_t nxt,
  output logic ok
);
  always_comb begin
    nxt = cur;
    ok  = 1'b0;
    if (hit) begin
      if (we) begin
        if (cur.busy && cur.owner == port) begin
          ok = 1'b1;
          if (rel) nxt.busy = 1'b0;
        end
      end else if (!cur.busy) begin
        nxt.busy  = 1'b1;
        nxt.owner = port;
        ok        = 1'b1;
      end else if (cur.owner == port) begin
        ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_hit,
  input  logic a_we,
  input  logic a_rel,
  input  logic b_hit,
  input  logic b_we,
  input  logic b_rel,
  input  logic b_first,
  output sem_t a_view,
  output sem_t b_view,
  output logic a_ok,
  output logic b_ok
);
  sem_t q;
  sem_t n0, n1;
  logic ok0, ok1;
  logic h0, w0, r0, p0, h1, w1, r1, p1;

  always_comb begin
    p0 = b_first ? PORT_B : PORT_A;
    p1 = ~p0;
    h0 = b_first ? b_hit : a_hit;
    w0 = b_first ? b_we  : a_we;
    r0 = b_first ? b_rel : a_rel;
    h1 = b_first ? a_hit : b_hit;
    w1 = b_first ? a_we  : b_we;
    r1 = b_first ? a_rel : b_rel;
  end

  sem_step u_first  (.cur(q),  .hit(h0), .we(w0), .rel(r0), .port(p0), .nxt(n0), .ok(ok0));
  sem_step u_second (.cur(n0), .hit(h1), .we(w1), .rel(r1), .port(p1), .nxt(n1), .ok(ok1));

  assign a_view = b_first ? n1  : n0;
  assign b_view = b_first ? n0  : n1;
  assign a_ok   = b_first ? ok1 : ok0;
  assign b_ok   = b_first ? ok0 : ok1;

  always_ff @(posedge clk) begin
    if (rst) q <= '{busy: 1'b0, owner: PORT_A};
    else     q <= n1;
  end

  assert_reset_free_R2: assert property (@(posedge clk) rst |=> (!q.busy && q.owner == PORT_A));
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !(a_hit || b_hit) |=> $stable(q));
  assert_owner_claim_R3: assert property (@(posedge clk) disable iff (rst)
    (q.owner != $past(q.owner)) |-> (q.owner ? $past(b_hit) : $past(a_hit)));
  assert_claim_free_R3: assert property (@(posedge clk) disable iff (rst)
    (a_hit && !a_we && !b_hit && !q.busy) |=> (q.busy && q.owner == PORT_A));
  assert_foreign_write_a_R7: assert property (@(posedge clk) disable iff (rst)
    (a_hit && a_we && !b_hit && q.busy && q.owner == PORT_B) |=> $stable(q));
  assert_foreign_write_b_R10: assert property (@(posedge clk) disable iff (rst)
    (b_hit && b_we && !a_hit && q.busy && q.owner == PORT_A) |=> $stable(q));
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int NSEM = 8,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NSEM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_req,
  input  logic          a_we,
  input  logic [IW-1:0] a_idx,
  input  logic [DW-1:0] a_wdata,
  input  logic          b_req,
  input  logic          b_we,
  input  logic [IW-1:0] b_idx,
  input  logic [DW-1:0] b_wdata,
  output logic          a_rvalid,
  output logic [DW-1:0] a_rdata,
  output logic          b_rvalid,
  output logic [DW-1:0] b_rdata
);
  logic [NSEM-1:0] a_hit, b_hit, a_ok_v, b_ok_v;
  logic            b_first;
  sem_t            a_view_v [NSEM];
  sem_t            b_view_v [NSEM];
  logic            a_rel, b_rel;
  logic [DW-1:0]   a_rsp, b_rsp;

  assign a_rel = (a_wdata == '0);
  assign b_rel = (b_wdata == '0);

  sem_route #(.NSEM(NSEM), .IW(IW)) u_route (
    .a_req(a_req), .a_we(a_we), .a_idx(a_idx),
    .b_req(b_req), .b_we(b_we), .b_idx(b_idx),
    .a_hit(a_hit), .b_hit(b_hit), .b_first(b_first)
  );

  for (genvar i = 0; i < NSEM; i++) begin : g_sem
    sem_cell u_cell (
      .clk(clk), .rst(rst),
      .a_hit(a_hit[i]), .a_we(a_we), .a_rel(a_rel),
      .b_hit(b_hit[i]), .b_we(b_we), .b_rel(b_rel),
      .b_first(b_first),
      .a_view(a_view_v[i]), .b_view(b_view_v[i]),
      .a_ok(a_ok_v[i]), .b_ok(b_ok_v[i])
    );
  end

  always_comb begin
    a_rsp = '0;
    b_rsp = '0;
    if (a_req) begin
      a_rsp[RSP_OK]  = a_ok_v[a_idx];
      a_rsp[RSP_OWN] = a_view_v[a_idx].owner;
      a_rsp[RSP_RES] = a_view_v[a_idx].busy;
    end
    if (b_req) begin
      b_rsp[RSP_OK]  = b_ok_v[b_idx];
      b_rsp[RSP_OWN] = b_view_v[b_idx].owner;
      b_rsp[RSP_RES] = b_view_v[b_idx].busy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
      a_rdata  <= '0;
      b_rdata  <= '0;
    end else begin
      a_rvalid <= a_req;
      b_rvalid <= b_req;
      a_rdata  <= a_rsp;
      b_rdata  <= b_rsp;
    end
  end

  assert_rvalid_a_R11: assert property (@(posedge clk) disable iff (rst) a_req |=> a_rvalid);
  assert_quiet_a_R11: assert property (@(posedge clk) disable iff (rst)
    !a_req |=> (!a_rvalid && a_rdata == '0));
  assert_rvalid_b_R10: assert property (@(posedge clk) disable iff (rst) b_req |=> b_rvalid);
  assert_single_grant_R9: assert property (@(posedge clk) disable iff (rst)
    (a_req && b_req && !a_we && !b_we && a_idx == b_idx) |=> (a_rdata[RSP_OK] != b_rdata[RSP_OK]));
  assert_write_first_R8: assert property (@(posedge clk) disable iff (rst)
    (a_req && !a_we && b_req && b_we && a_idx == b_idx && b_wdata == '0)
    |=> (!b_rdata[RSP_OK] || a_rdata[RSP_OK]));
endmodule

// File: tb/sem_bank_bench.sv
module sem_bank_bench;
  localparam int NSEM = 8;
  localparam int DW   = 8;
  localparam int IW   = $clog2(NSEM);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [IW-1:0] a_idx = '0, b_idx = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic          a_rvalid, b_rvalid;
  logic [DW-1:0] a_rdata, b_rdata;

  int total = 0;
  int bad   = 0;

  bit busy_m [NSEM];
  bit own_m  [NSEM];
  logic          exp_av = 0, exp_bv = 0;
  logic [DW-1:0] exp_a = '0, exp_b = '0;
  string         cur_tag = "R2";

  always #4 clk = ~clk;

  sem_bank #(.NSEM(NSEM), .DW(DW)) u_sem_bank (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_we(a_we), .a_idx(a_idx), .a_wdata(a_wdata),
    .b_req(b_req), .b_we(b_we), .b_idx(b_idx), .b_wdata(b_wdata),
    .a_rvalid(a_rvalid), .a_rdata(a_rdata),
    .b_rvalid(b_rvalid), .b_rdata(b_rdata)
  );

  function automatic logic [DW-1:0] mstep(bit port, bit we, logic [DW-1:0] wd, int idx);
    bit ok = 0;
    logic [DW-1:0] r = '0;
    if (we) begin
      if (busy_m[idx] && own_m[idx] == port) begin
        ok = 1;
        if (wd == 0) busy_m[idx] = 0;
      end
    end else if (!busy_m[idx]) begin
      busy_m[idx] = 1;
      own_m[idx]  = port;
      ok = 1;
    end else if (own_m[idx] == port) begin
      ok = 1;
    end
    r[0] = ok;
    r[1] = own_m[idx];
    r[2] = busy_m[idx];
    return r;
  endfunction

  task automatic check_outputs();
    total++;
    if (a_rvalid !== exp_av || a_rdata !== exp_a) begin
      bad++;
      $display("FAIL %s port A: got v=%0b d=%h expected v=%0b d=%h", cur_tag, a_rvalid, a_rdata, exp_av, exp_a);
    end
    total++;
    if (b_rvalid !== exp_bv || b_rdata !== exp_b) begin
      bad++;
      $display("FAIL %s port B: got v=%0b d=%h expected v=%0b d=%h", cur_tag, b_rvalid, b_rdata, exp_bv, exp_b);
    end
  endtask

  task automatic op(bit ar, bit aw, int ai, logic [DW-1:0] ad,
                    bit br, bit bw, int bi, logic [DW-1:0] bd, string tag);
    @(negedge clk);
    check_outputs();
    a_req = ar; a_we = aw; a_idx = IW'(ai); a_wdata = ad;
    b_req = br; b_we = bw; b_idx = IW'(bi); b_wdata = bd;
    cur_tag = tag;
    exp_av = ar; exp_bv = br; exp_a = '0; exp_b = '0;
    if (ar && br && ai == bi && bw && !aw) begin
      exp_b = mstep(1, bw, bd, bi);
      exp_a = mstep(0, aw, ad, ai);
    end else begin
      if (ar) exp_a = mstep(0, aw, ad, ai);
      if (br) exp_b = mstep(1, bw, bd, bi);
    end
  endtask

  task automatic idle(string tag);
    op(0, 0, 0, '0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSEM; i++) begin busy_m[i] = 0; own_m[i] = 0; end
    // R2: outputs quiet while reset is held
    repeat (3) begin
      @(negedge clk);
      check_outputs();
    end
    rst = 1'b0;
    // R2: every semaphore starts free; claim and release each from port A
    for (int i = 0; i < NSEM; i++) begin
      op(1, 0, i, '0, 0, 0, 0, '0, "R2");
      op(1, 1, i, '0, 0, 0, 0, '0, "R2");
    end
    op(1, 0, 3, '0, 0, 0, 0, '0, "R3");
    op(0, 0, 0, '0, 1, 0, 3, '0, "R4");
    op(1, 0, 3, '0, 0, 0, 0, '0, "R5");
    op(0, 0, 0, '0, 1, 1, 3, '0, "R7");
    op(0, 0, 0, '0, 1, 0, 3, '0, "R7");
    op(1, 1, 3, 8'h01, 0, 0, 0, '0, "R6");
    op(0, 0, 0, '0, 1, 0, 3, '0, "R6");
    op(1, 1, 3, '0, 0, 0, 0, '0, "R6");
    op(0, 0, 0, '0, 1, 0, 3, '0, "R6");
    op(1, 0, 3, '0, 0, 0, 0, '0, "R10");
    op(1, 1, 3, '0, 0, 0, 0, '0, "R10");
    op(1, 0, 3, '0, 0, 0, 0, '0, "R10");
    op(1, 1, 4, 8'h5a, 0, 0, 0, '0, "R7");
    op(1, 0, 4, '0, 0, 0, 0, '0, "R7");
    // R8: releasing write beats the other port's read
    op(1, 0, 3, '0, 1, 1, 3, '0, "R8");
    op(0, 0, 0, '0, 1, 0, 5, '0, "R8");
    op(0, 0, 0, '0, 0, 0, 0, '0, "R8");
    op(1, 1, 5, '0, 1, 0, 5, '0, "R8");
    op(1, 0, 5, '0, 1, 1, 5, '0, "R8");
    // R9: same-index double read and double write, A first
    op(1, 0, 6, '0, 1, 0, 6, '0, "R9");
    op(1, 1, 6, 8'h02, 1, 1, 6, '0, "R9");
    op(1, 1, 6, '0, 1, 1, 6, '0, "R9");
    op(1, 0, 6, '0, 1, 0, 6, '0, "R9");
    // R1: different indices in one cycle are independent
    op(1, 0, 1, '0, 1, 0, 2, '0, "R1");
    op(1, 0, 2, '0, 1, 0, 1, '0, "R1");
    op(1, 0, 0, '0, 1, 0, 7, '0, "R1");
    idle("R11");
    idle("R11");
    for (int n = 0; n < 3000; n++) begin
      bit ar = ($urandom % 4) != 0;
      bit br = ($urandom % 4) != 0;
      logic [DW-1:0] ad = ($urandom % 2) ? '0 : DW'($urandom % 256);
      logic [DW-1:0] bd = ($urandom % 2) ? '0 : DW'($urandom % 256);
      op(ar, bit'($urandom % 2), int'($urandom % 4), ad,
         br, bit'($urandom % 2), int'($urandom % 4), bd, "R10");
    end
    idle("R11");
    @(negedge clk);
    check_outputs();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule